// File: doc/BRIEF.md
# Pipelined Accuracy-Selectable Segmented Adder

This block adds two unsigned operands in a short pipeline whose first stage forms a fast, possibly wrong sum from independent fixed-width segments. Each segment guesses its carry-in from only a few operand bits just below its lower edge. Each later stage repairs one segment boundary, in order from the least significant upward, by working out the true carry at that boundary. If the guess was wrong, it adds one into the segment above. After all stages have run, the sum is exact.

A mode code arrives with every operand pair. It sets how many stages that operation passes through. The stages beyond that count are never loaded for the operation, and their registers keep their old contents, which stands in for switching them off. The result is taken from the last stage the operation reaches, so fewer stages give a shorter latency and a less accurate result. The mode travels with the operation, so operations with different modes can follow each other with no flush. When a new operation would finish in the same cycle as one already in flight, the block lowers its ready signal for that cycle. Alongside the sum, the block outputs a flag that is set only when the result is known to be exact.

Default instance: 32-bit operands, four stages, 8-bit segments, 4-bit carry guess window.

Top module: `seg_acc_adder`

## Requirements
- R1: While rst_n is low at a clock edge, and at the first sample after that edge, out_valid is 0 and in_ready is 1.
- R2: in_mode code m (0 to 3) selects 4-m active stages. An operation accepted at rising edge t raises out_valid for exactly one cycle, in the cycle that follows edge t+(4-m)-1.
- R3: The first stage splits each operand into 8-bit segments (segment s holds bits 8s+7..8s). The carry-in of segment 0 is 0. For every higher segment s, the carry-in is the carry out of the 4 bits 8s-1..8s-4 added with carry-in 0. Each segment sum is taken modulo 256, and the carry out of bit 31 is dropped.
- R4: Stage k+1 (k = 1 to 3) computes the true carry into bit 8k-4. When that carry is 1 and all four bits 8k-1..8k-4 of a XOR b are 1, it adds one, modulo 256, to segment k. Otherwise segment k passes through unchanged.
- R5: In mode 0, out_sum always equals (in_a + in_b) mod 2^32 and out_exact is 1.
- R6: out_exact is 1 exactly when no uncorrected boundary k (k ≥ number of active stages) has a XOR b all ones in bits 8k-1..8k-4. Whenever out_exact is 1, out_sum is the exact sum.
- R7: An operation never enters a stage beyond its active count. Such a stage's registers hold their contents, and no extra output appears for the operation.
- R8: Each operation carries its own mode. Consecutive operations with different modes each produce the result their own mode defines.
- R9: in_ready is low exactly when an operation accepted now, with the presented mode, would leave in the same cycle as an operation already in flight. An in_valid pulse while in_ready is low is ignored and produces no output.
- R10: At most one operation leaves the pipeline in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair and mode presented |
| in_ready | output | 1 | Presented operation can be accepted this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_mode | input | 2 | Accuracy code, 0 = all stages (exact), 3 = first stage only |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | 32 | Sum from the last active stage of the leaving operation |
| out_exact | output | 1 | Result is known to equal the exact sum |

## Verification
On every cycle, the embedded assertions check the following. At most one stage is leaving at a time. A refused request never loads the first stage. A one-stage operation appears one edge after acceptance. No operation sits in a stage beyond its active count. A repair stage passes a segment through untouched when its window cannot carry. A result from the final stage always carries the exact flag. The arithmetic content can only be shown by the bench's scenarios: the guessed carries, the step-by-step repair of each boundary, the exact-flag rule for unrepaired windows, and the ready collisions between mixed modes. The bench checks these against a model built from the segment rules, and it reports how often each mode is wrong and by how many bits.

// File: rtl/seg_acc_pkg.sv
// seg_acc_pkg: helpers shared by the segmented adder stages.
// Assumes segment widths never exceed 64 bits.
package seg_acc_pkg;

    // Ripple carry out of the low n bits of x+y with carry-in cin.
    function automatic logic carry_of(input logic [63:0] x, input logic [63:0] y,
                                      input logic cin, input int n);
        logic c;
        c = cin;
        for (int i = 0; i < n; i++) begin
            c = (x[i] & y[i]) | ((x[i] ^ y[i]) & c);
        end
        return c;
    endfunction

    // Active stage count for a mode code; codes past the stage count fall back to all stages.
    function automatic int active_from_mode(input int code, input int nstg);
        return (code < nstg) ? (nstg - code) : nstg;
    endfunction

endpackage

// File: rtl/seg_acc_seed_stage.sv
// seg_acc_seed_stage: first pipeline stage. Forms the speculative sum of
// independent segments, each guessing its carry-in from LOOK bits below its
// edge, and records which boundaries could be wrong (window fully propagating).
// Assumes LOOK <= SEG and NSTG >= 2.
module seg_acc_seed_stage #(
    parameter int WIDTH = 32,
    parameter int NSTG  = 4,
    parameter int LOOK  = 4,
    parameter int MW    = 2,
    parameter int AW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic [MW-1:0]     mode_i,
    output logic              v_q,
    output logic [WIDTH-1:0]  a_q,
    output logic [WIDTH-1:0]  b_q,
    output logic [WIDTH-1:0]  sum_q,
    output logic [NSTG-1:1]   pend_q,
    output logic              crun_q,
    output logic [AW-1:0]     act_q
);
    import seg_acc_pkg::*;

    localparam int SEG = WIDTH / NSTG;

    logic [WIDTH-1:0] sum_d;
    logic [NSTG-1:1]  pend_d;
    logic [AW-1:0]    act_d;

    assign act_d = AW'(active_from_mode(int'(mode_i), NSTG));

    for (genvar s = 0; s < NSTG; s++) begin : g_seg
        logic spec_c;
        if (s == 0) begin : g_base
            assign spec_c = 1'b0;
        end else begin : g_upper
            logic [SEG-1:0] lo_a, lo_b;
            assign lo_a      = a_i[(s-1)*SEG +: SEG];
            assign lo_b      = b_i[(s-1)*SEG +: SEG];
            // guessed carry: top LOOK bits of the segment below, carry-in forced to 0
            assign spec_c    = carry_of(64'(lo_a >> (SEG-LOOK)), 64'(lo_b >> (SEG-LOOK)), 1'b0, LOOK);
            // a guess can only be wrong when the whole window propagates
            assign pend_d[s] = &(a_i[s*SEG-1 -: LOOK] ^ b_i[s*SEG-1 -: LOOK]);
        end
        assign sum_d[s*SEG +: SEG] = a_i[s*SEG +: SEG] + b_i[s*SEG +: SEG] + SEG'(spec_c);
    end

    // Valid follows the accept strobe every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= load;
    end

    // Payload registers load only on accept and otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            pend_q <= '0;
        end else if (load) begin
            a_q    <= a_i;
            b_q    <= b_i;
            sum_q  <= sum_d;
            pend_q <= pend_d;
            act_q  <= act_d;
        end
    end

    // True carry into segment 0 is always zero.
    assign crun_q = 1'b0;

endmodule

// File: rtl/seg_acc_fix_stage.sv
// seg_acc_fix_stage: repairs boundary BIDX. Extends the true carry through
// segment BIDX-1, raises an error when the guess window propagated a real
// carry, increments segment BIDX modulo 2^SEG, and passes the carry onward.
// Assumes the incoming carry is the true carry into segment BIDX-1.
module seg_acc_fix_stage #(
    parameter int WIDTH = 32,
    parameter int NSTG  = 4,
    parameter int LOOK  = 4,
    parameter int AW    = 3,
    parameter int BIDX  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    input  logic [WIDTH-1:0]  sum_i,
    input  logic [NSTG-1:1]   pend_i,
    input  logic              crun_i,
    input  logic [AW-1:0]     act_i,
    output logic              v_q,
    output logic [WIDTH-1:0]  a_q,
    output logic [WIDTH-1:0]  b_q,
    output logic [WIDTH-1:0]  sum_q,
    output logic [NSTG-1:1]   pend_q,
    output logic              crun_q,
    output logic [AW-1:0]     act_q
);
    import seg_acc_pkg::*;

    localparam int SEG = WIDTH / NSTG;

    logic [SEG-1:0]   lo_a, lo_b;
    logic             win_cin, fix_err, crun_d;
    logic [WIDTH-1:0] sum_d;
    logic [NSTG-1:1]  pend_d;

    assign lo_a = a_i[(BIDX-1)*SEG +: SEG];
    assign lo_b = b_i[(BIDX-1)*SEG +: SEG];

    // True carry into the window, then out of the whole lower segment.
    always_comb begin
        win_cin = carry_of(64'(lo_a), 64'(lo_b), crun_i, SEG-LOOK);
        crun_d  = carry_of(64'(lo_a >> (SEG-LOOK)), 64'(lo_b >> (SEG-LOOK)), win_cin, LOOK);
        fix_err = pend_i[BIDX] & win_cin;
    end

    // Increment the affected segment and retire its pending mark.
    always_comb begin
        sum_d                    = sum_i;
        sum_d[BIDX*SEG +: SEG]   = sum_i[BIDX*SEG +: SEG] + SEG'(fix_err);
        pend_d                   = pend_i;
        pend_d[BIDX]             = 1'b0;
    end

    // Valid follows the forward strobe of the previous stage.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= load;
    end

    // Payload registers are clock-enabled; an idle stage keeps its contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            pend_q <= '0;
            crun_q <= 1'b0;
        end else if (load) begin
            a_q    <= a_i;
            b_q    <= b_i;
            sum_q  <= sum_d;
            pend_q <= pend_d;
            crun_q <= crun_d;
            act_q  <= act_i;
        end
    end

    // R7: an operation only occupies a stage inside its active count
    a_r7_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (act_q > AW'(BIDX)));

    // R7: an idle stage holds its operands
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(a_q) && $stable(sum_q));

    // R4: no correction when the window cannot have carried
    a_r4_quiet_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !pend_i[BIDX]) |=> (sum_q == $past(sum_i)));

endmodule

// File: rtl/seg_acc_exit_sel.sv
// seg_acc_exit_sel: picks the result of the stage whose operation leaves
// this cycle. Assumes at most one exit bit is set.
module seg_acc_exit_sel #(
    parameter int WIDTH = 32,
    parameter int NSTG  = 4
) (
    input  logic [NSTG-1:0]  exit_vec,
    input  logic [WIDTH-1:0] sum_a  [NSTG],
    input  logic [NSTG-1:1]  pend_a [NSTG],
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_exact
);
    // Select sum and exactness from the leaving stage.
    always_comb begin
        out_sum   = '0;
        out_exact = 1'b0;
        for (int i = 0; i < NSTG; i++) begin
            if (exit_vec[i]) begin
                out_sum   = sum_a[i];
                out_exact = ~|pend_a[i];
            end
        end
    end

    assign out_valid = |exit_vec;

endmodule

// File: rtl/seg_acc_adder.sv
// seg_acc_adder: top of the accuracy-selectable pipelined adder. Wires a
// seed stage and NSTG-1 repair stages, forwards each operation only as far
// as its mode allows, taps the result from its last stage, and refuses an
// input that would leave in the same cycle as an in-flight operation.
// Assumes WIDTH divisible by NSTG, NSTG >= 2, 1 <= LOOK <= WIDTH/NSTG.
module seg_acc_adder #(
    parameter int WIDTH = 32,
    parameter int NSTG  = 4,
    parameter int LOOK  = 4,
    parameter int MW    = (NSTG > 1) ? $clog2(NSTG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [MW-1:0]    in_mode,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_exact
);
    import seg_acc_pkg::*;

    localparam int AW = $clog2(NSTG + 1);

    logic             st_v    [NSTG];
    logic [WIDTH-1:0] st_a    [NSTG];
    logic [WIDTH-1:0] st_b    [NSTG];
    logic [WIDTH-1:0] st_sum  [NSTG];
    logic [NSTG-1:1]  st_pend [NSTG];
    logic             st_crun [NSTG];
    logic [AW-1:0]    st_act  [NSTG];

    logic [NSTG-1:0]  exit_vec, fwd_vec, clash_vec;
    logic [AW-1:0]    act_in;
    logic             accept;

    assign act_in = AW'(active_from_mode(int'(in_mode), NSTG));

    // Per-stage leave, forward and collision decisions.
    for (genvar i = 0; i < NSTG; i++) begin : g_ctl
        assign exit_vec[i]  = st_v[i] && (st_act[i] == AW'(i+1));
        assign fwd_vec[i]   = st_v[i] && (st_act[i] >  AW'(i+1));
        assign clash_vec[i] = fwd_vec[i] && ((st_act[i] - AW'(i+1)) == act_in);
    end

    assign in_ready = ~|clash_vec;
    assign accept   = in_valid && in_ready;

    seg_acc_seed_stage #(
        .WIDTH(WIDTH), .NSTG(NSTG), .LOOK(LOOK), .MW(MW), .AW(AW)
    ) seed_i (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .a_i(in_a), .b_i(in_b), .mode_i(in_mode),
        .v_q(st_v[0]), .a_q(st_a[0]), .b_q(st_b[0]), .sum_q(st_sum[0]),
        .pend_q(st_pend[0]), .crun_q(st_crun[0]), .act_q(st_act[0])
    );

    for (genvar k = 1; k < NSTG; k++) begin : g_fix
        seg_acc_fix_stage #(
            .WIDTH(WIDTH), .NSTG(NSTG), .LOOK(LOOK), .AW(AW), .BIDX(k)
        ) fix_i (
            .clk(clk), .rst_n(rst_n), .load(fwd_vec[k-1]),
            .a_i(st_a[k-1]), .b_i(st_b[k-1]), .sum_i(st_sum[k-1]),
            .pend_i(st_pend[k-1]), .crun_i(st_crun[k-1]), .act_i(st_act[k-1]),
            .v_q(st_v[k]), .a_q(st_a[k]), .b_q(st_b[k]), .sum_q(st_sum[k]),
            .pend_q(st_pend[k]), .crun_q(st_crun[k]), .act_q(st_act[k])
        );
    end

    seg_acc_exit_sel #(.WIDTH(WIDTH), .NSTG(NSTG)) exit_i (
        .exit_vec(exit_vec), .sum_a(st_sum), .pend_a(st_pend),
        .out_valid(out_valid), .out_sum(out_sum), .out_exact(out_exact)
    );

    // R10: a single leaving operation per cycle
    a_r10_one_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exit_vec));

    // R9: a refused request never reaches the first stage
    a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> !st_v[0]);

    // R2: a one-stage operation leaves right after acceptance
    a_r2_short_path: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && act_in == AW'(1)) |=> out_valid);

    // R5: results from the final stage are always marked exact
    a_r5_full_exact: assert property (@(posedge clk) disable iff (!rst_n)
        exit_vec[NSTG-1] |-> out_exact);

endmodule

// File: tb/seg_acc_adder_tb.sv
// Bench for seg_acc_adder: fixed-seed random mixed-mode traffic plus
// directed carry corner cases, scored per cycle against a segment model.
module seg_acc_adder_tb_top;

    localparam int W    = 32;
    localparam int NS   = 4;
    localparam int SG   = 8;
    localparam int LK   = 4;
    localparam int RING = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic [1:0]    in_mode = '0;
    logic          out_valid;
    logic [W-1:0]  out_sum;
    logic          out_exact;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    bit           slot_v [RING];
    logic [W-1:0] slot_a [RING];
    logic [W-1:0] slot_b [RING];
    int           slot_m [RING];

    int ops_m [4];
    int miss_m [4];
    int bits_m [4];

    always #2 clk = ~clk;

    seg_acc_adder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_mode(in_mode),
        .out_valid(out_valid), .out_sum(out_sum), .out_exact(out_exact)
    );

    // True carry into bit pos of a+b.
    function automatic logic true_carry(input logic [W-1:0] a, input logic [W-1:0] b, input int pos);
        logic [63:0] m, t;
        m = (64'd1 << pos) - 64'd1;
        t = ({32'd0, a} & m) + ({32'd0, b} & m);
        return t[pos];
    endfunction

    // Expected sum with boundaries below act repaired (R3, R4).
    function automatic logic [W-1:0] model_sum(input logic [W-1:0] a, input logic [W-1:0] b, input int act);
        logic [W-1:0] r;
        int cin, wa, wb;
        r = '0;
        for (int s = 0; s < NS; s++) begin
            if (s == 0) cin = 0;
            else if (s < act) cin = int'(true_carry(a, b, s*SG));
            else begin
                wa  = int'((a >> (s*SG-LK)) & 32'hF);
                wb  = int'((b >> (s*SG-LK)) & 32'hF);
                cin = (wa + wb >= 16) ? 1 : 0;
            end
            r[s*SG +: SG] = 8'(int'(a[s*SG +: SG]) + int'(b[s*SG +: SG]) + cin);
        end
        return r;
    endfunction

    // Expected exact flag (R6).
    function automatic logic model_exact(input logic [W-1:0] a, input logic [W-1:0] b, input int act);
        logic f;
        f = 1'b1;
        for (int s = 1; s < NS; s++)
            if (s >= act && (((a ^ b) >> (s*SG-LK)) & 32'hF) == 32'hF) f = 1'b0;
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act_v, input logic [W-1:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act_v, exp_v);
        end
    endtask

    // One bench cycle: score outputs at the negedge, then present the next input.
    task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b, input int m);
        int idx, act, tgt;
        logic [W-1:0] es, ex;
        logic ee;
        @(negedge clk);
        idx = cyc % RING;
        if (slot_v[idx]) begin
            act = NS - slot_m[idx];
            es  = model_sum(slot_a[idx], slot_b[idx], act);
            ee  = model_exact(slot_a[idx], slot_b[idx], act);
            ex  = slot_a[idx] + slot_b[idx];
            check(out_valid == 1'b1, "R2 latency", W'(out_valid), 1);
            if (act == NS) begin
                check(out_sum == ex, "R5 exact sum", out_sum, ex);
                check(out_exact == 1'b1, "R5 exact flag", W'(out_exact), 1);
            end else begin
                check(out_sum == es, "R4 repaired sum", out_sum, es);
            end
            check(out_exact == ee, "R6 exact flag", W'(out_exact), W'(ee));
            if (out_exact) check(out_sum == ex, "R6 flagged exact", out_sum, ex);
            ops_m[slot_m[idx]]++;
            if (out_sum != ex) begin
                miss_m[slot_m[idx]]++;
                bits_m[slot_m[idx]] += $countones(out_sum ^ ex);
            end
            slot_v[idx] = 1'b0;
        end else begin
            check(out_valid == 1'b0, "R7 R10 no stray output", W'(out_valid), 0);
        end
        in_valid = v; in_a = a; in_b = b; in_mode = 2'(m);
        #1;
        act = NS - m;
        tgt = (cyc + act) % RING;
        check(in_ready == !slot_v[tgt], "R9 ready", W'(in_ready), W'(!slot_v[tgt]));
        if (v && !slot_v[tgt]) begin
            slot_v[tgt] = 1'b1; slot_a[tgt] = a; slot_b[tgt] = b; slot_m[tgt] = m;
        end
        cyc++;
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) step(1'b0, '0, '0, 0);
    endtask

    initial begin
        int seed, mm;
        logic [W-1:0] ra, rb;
        seed = $urandom(32'h5EED_0A1C);
        for (int i = 0; i < RING; i++) slot_v[i] = 1'b0;
        for (int i = 0; i < 4; i++) begin ops_m[i] = 0; miss_m[i] = 0; bits_m[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 reset valid", W'(out_valid), 0);
        check(in_ready == 1'b1, "R1 reset ready", W'(in_ready), 1);

        // Directed: window propagates a real carry at boundary 1, every mode (R3 R4 R6).
        for (int m = 0; m < 4; m++) begin step(1'b1, 32'h0000_00F8, 32'h0000_0008, m); drain(); end
        // Directed: full ripple across all boundaries.
        for (int m = 0; m < 4; m++) begin step(1'b1, 32'hFFFF_FFFF, 32'h0000_0001, m); drain(); end
        // Directed: guessed carries all correct, exact flag expected in every mode.
        for (int m = 0; m < 4; m++) begin step(1'b1, 32'h1234_5678, 32'h0101_0101, m); drain(); end
        // Directed collision: deep op then op that would leave with it (R9).
        step(1'b1, 32'h0000_0010, 32'h0000_0020, 0);
        step(1'b1, 32'h0000_0003, 32'h0000_0004, 1);
        step(1'b1, 32'h0000_0005, 32'h0000_0006, 3);
        drain();
        // Back-to-back mode changes without flush (R8).
        for (int m = 3; m >= 0; m--) step(1'b1, 32'h8F0F_F0F8, 32'h70F1_0F08, m);
        drain();

        // Random mixed-mode traffic with idle gaps.
        for (int i = 0; i < 3000; i++) begin
            ra = $urandom; rb = $urandom;
            if ($urandom_range(0, 3) == 0) rb = ~ra ^ (32'h1 << $urandom_range(0, 31));
            mm = $urandom_range(0, 3);
            step($urandom_range(0, 4) != 0, ra, rb, mm);
        end
        drain();

        for (int m = 0; m < 4; m++)
            $display("mode %0d: %0d results, %0d differ from exact, %0d wrong bits in total",
                     m, ops_m[m], miss_m[m], bits_m[m]);
        check(miss_m[0] == 0, "R5 mode 0 never wrong", W'(miss_m[0]), 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog cycle %0d actual hung expected finished", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule